// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block sits between a single request source and an SDRAM device. It turns each read or write request into an ACTIVE command followed by a READ or WRITE command with auto-precharge. Every access therefore closes its own row, and the block never keeps a page open between requests. All minimum spacings are counted in clock cycles, so a new command is only driven once every interval that applies to it has passed. The intervals covered are row-to-column delay, auto-precharge completion, refresh cycle time and mode-load settling.

After reset the block runs the power-up sequence by itself. It waits a programmable number of cycles and then issues PRECHARGE ALL. Two AUTO REFRESH commands follow, and then LOAD MODE REGISTER. A free-running interval timer then requests AUTO REFRESH at a fixed rate. A pending refresh is served only between accesses, and it goes ahead of a waiting request.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and all request fields steady until that edge. `req_ready` is low in three cases: during power-up, from an acceptance until the spacing after the access has elapsed, and while a refresh is pending.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted and until the power-up sequence ends, `req_ready` is low. During reset the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111).
- R2: After reset is released, the commands follow this order and spacing:
  - PRECHARGE ALL with addr[10]=1 on the INIT_WAIT-th clock edge.
  - AUTO REFRESH T_RP cycles later.
  - A second AUTO REFRESH T_RFC cycles after that.
  - LOAD MODE REGISTER T_RFC cycles after that. Its addr value has CAS_LAT in bits 6:4 and zero in all other bits (burst length one, sequential, programmed write burst).
  - A request that is already waiting gets its ACTIVE exactly T_MRD cycles after LOAD MODE REGISTER.
- R3: A request accepted on an edge produces ACTIVE in the next cycle. ACTIVE carries the request's bank on `ba` and its row on `addr`.
- R4: READ (when `req_write` is 0) or WRITE (when `req_write` is 1) follows ACTIVE by exactly T_RCD cycles. It uses the same bank, with the column on addr[9:0], addr[10]=1 for auto-precharge, and addr[12:11]=0.
- R5: After a READ or WRITE, no command is issued for GAP cycles, where GAP is the largest of:
  - T_RC−T_RCD
  - T_RAS−T_RCD+T_RP
  - T_WR+T_RP
  
  GAP is 7 at the default values. If a request or refresh is waiting, the next command comes exactly GAP cycles after the READ or WRITE.
- R6: Once power-up ends, a refresh becomes pending every REF_INTERVAL cycles. A pending refresh is served before a waiting request. AUTO REFRESH never appears between an ACTIVE and its READ/WRITE. With no requests, consecutive AUTO REFRESH commands are exactly REF_INTERVAL cycles apart.
- R7: After an AUTO REFRESH, no command is issued for T_RFC cycles.
- R8: `req_ready` is low in the cycle after an acceptance. While `req_valid` is low, no ACTIVE is issued, whatever the request fields hold.
- R9: The command encodings on {cs_n,ras_n,cas_n,we_n} are:

  | Command | Code |
  |---|---|
  | ACTIVE | 0011 |
  | READ | 0101 |
  | WRITE | 0100 |
  | PRECHARGE | 0010 |
  | AUTO REFRESH | 0001 |
  | LOAD MODE REGISTER | 0000 |
  | NOP | 0111 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Starting column |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Row, column or mode value |

## Verification
The bench builds the block with INIT_WAIT=20, REF_INTERVAL=200 and CAS_LAT=2. It keeps the default cycle counts for the timing limits. The short power-up wait lets the bench check the whole init order and spacing, along with the exact cycle of the first ACTIVE. The short refresh interval lets several refreshes fall inside both a continuous request stream and an idle stretch, which exercises the priority rule and the exact idle refresh spacing. CAS_LAT=2 makes the expected mode word differ from the default one.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdcmd_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
  parameter int unsigned CW      = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CW'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned INTERVAL = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pend
);

  localparam int unsigned TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = run && (tcnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      pend <= 1'b0;
    end else begin
      if (!run || tick) tcnt <= '0;
      else              tcnt <= tcnt + 1'b1;
      pend <= tick | (pend & ~ack);
    end
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned INIT_WAIT    = 13300,
  parameter int unsigned REF_INTERVAL = 1040,
  parameter int unsigned T_RCD        = 3,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RAS        = 7,
  parameter int unsigned T_RC         = 10,
  parameter int unsigned T_RFC        = 10,
  parameter int unsigned T_WR         = 2,
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned CAS_LAT      = 3,
  parameter int unsigned BANK_W       = 2,
  parameter int unsigned ROW_W        = 13,
  parameter int unsigned COL_W        = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr
);

  // Cycles from READ/WRITE with auto-precharge until the bank is usable again
  localparam int unsigned AP_GAP = imax(T_RC - T_RCD,
                                   imax(T_RAS - T_RCD + T_RP, T_WR + T_RP));
  localparam int unsigned CW     = $clog2(imax(INIT_WAIT,
                                   imax(AP_GAP, imax(T_RFC, T_RP))) + 1);
  localparam int unsigned AP_BIT = 10;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT * 16);

  typedef enum logic [2:0] {
    PH_POWER, PH_REF1, PH_REF2, PH_MODE, PH_IDLE, PH_OPEN
  } phase_e;

  phase_e            phase_q, phase_d;
  sdcmd_e            cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d, bank_q;
  logic [ROW_W-1:0]  addr_q, addr_d;
  logic [COL_W-1:0]  col_q;
  logic              write_q;
  logic              load;
  logic [CW-1:0]     load_val;
  logic              expired;
  logic              ref_pend, ref_ack, run;
  logic              accept;

  sdram_gap_counter #(.CW(CW), .RST_VAL(INIT_WAIT - 1)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  assign run = (phase_q == PH_IDLE) || (phase_q == PH_OPEN);

  sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  assign req_ready = (phase_q == PH_IDLE) && expired && !ref_pend;
  assign accept    = req_valid && req_ready;

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    load     = 1'b0;
    load_val = '0;
    ref_ack  = 1'b0;
    if (expired) begin
      unique case (phase_q)
        PH_POWER: begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          load           = 1'b1;
          load_val       = CW'(T_RP - 1);
          phase_d        = PH_REF1;
        end
        PH_REF1, PH_REF2: begin
          cmd_d    = CMD_REF;
          load     = 1'b1;
          load_val = CW'(T_RFC - 1);
          phase_d  = (phase_q == PH_REF1) ? PH_REF2 : PH_MODE;
        end
        PH_MODE: begin
          cmd_d    = CMD_LMR;
          addr_d   = MODE_WORD;
          load     = 1'b1;
          load_val = CW'(T_MRD - 1);
          phase_d  = PH_IDLE;
        end
        PH_IDLE: begin
          if (ref_pend) begin
            cmd_d    = CMD_REF;
            ref_ack  = 1'b1;
            load     = 1'b1;
            load_val = CW'(T_RFC - 1);
          end else if (req_valid) begin
            cmd_d    = CMD_ACT;
            ba_d     = req_bank;
            addr_d   = req_row;
            load     = 1'b1;
            load_val = CW'(T_RCD - 1);
            phase_d  = PH_OPEN;
          end
        end
        PH_OPEN: begin
          cmd_d               = write_q ? CMD_WR : CMD_RD;
          ba_d                = bank_q;
          addr_d[COL_W-1:0]   = col_q;
          addr_d[AP_BIT]      = 1'b1;
          load                = 1'b1;
          load_val            = CW'(AP_GAP - 1);
          phase_d             = PH_IDLE;
        end
        default: phase_d = PH_POWER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_POWER;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      bank_q  <= '0;
      col_q   <= '0;
      write_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      if (accept) begin
        bank_q  <= req_bank;
        col_q   <= req_col;
        write_q <= req_write;
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RFC  = 10,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ROW_W-1:0]  addr
);

  logic [3:0] cmd;
  logic       is_act, is_rw, is_ref, is_cmd;
  logic [7:0] since_act, since_ref;
  logic       open_q;

  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_act = (cmd == CMD_ACT);
  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_ref = (cmd == CMD_REF);
  assign is_cmd = !cs_n && (cmd != CMD_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      since_ref <= 8'hFF;
      open_q    <= 1'b0;
    end else begin
      since_act <= is_act ? 8'd1 : ((since_act != 8'hFF) ? since_act + 8'd1 : since_act);
      since_ref <= is_ref ? 8'd1 : ((since_ref != 8'hFF) ? since_ref + 8'd1 : since_ref);
      if (is_act)     open_q <= 1'b1;
      else if (is_rw) open_q <= 1'b0;
    end
  end

  // R3
  accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (is_act && ba == $past(req_bank) && addr == $past(req_row)));

  // R8
  act_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> $past(req_valid && req_ready));

  // R4
  rcd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (open_q && since_act == 8'(T_RCD) && addr[10]));

  // R6
  ref_outside_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> !is_ref);

  // R7
  rfc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_ref >= 8'(T_RFC)));

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .T_RCD  (T_RCD),
  .T_RFC  (T_RFC),
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_bank  (req_bank),
  .req_row   (req_row),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr)
);

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;

  localparam int INIT_WAIT    = 20;
  localparam int REF_INTERVAL = 200;
  localparam int CAS_LAT      = 2;
  localparam int T_RCD = 3, T_RP = 3, T_RFC = 10, T_MRD = 2;
  localparam int AP_GAP = 7;  // max(10-3, 7-3+3, 2+3)

  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                         C_NOP = 4'b0111;

  // {write, bank, row, col}
  localparam logic [25:0] VECS [0:5] = '{
    {1'b0, 2'd0, 13'h0000, 10'h000},
    {1'b1, 2'd3, 13'h1FFF, 10'h3FF},
    {1'b0, 2'd1, 13'h0ABC, 10'h155},
    {1'b1, 2'd2, 13'h1555, 10'h2AA},
    {1'b1, 2'd0, 13'h0001, 10'h001},
    {1'b0, 2'd3, 13'h1000, 10'h200}
  };

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_bank = 0;
  logic [12:0] req_row = 0;
  logic [9:0]  req_col = 0;
  logic        req_ready, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;

  sdram_cmd_seq #(
    .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INTERVAL), .CAS_LAT(CAS_LAT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, n_log = 0;
  logic [3:0]  lg_cmd  [0:1023];
  logic [1:0]  lg_ba   [0:1023];
  logic [12:0] lg_addr [0:1023];
  int          lg_cyc  [0:1023];

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && {cs_n, ras_n, cas_n, we_n} != C_NOP && n_log < 1024) begin
      lg_cmd[n_log]  = {cs_n, ras_n, cas_n, we_n};
      lg_ba[n_log]   = ba;
      lg_addr[n_log] = addr;
      lg_cyc[n_log]  = cyc;
      n_log++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [25:0] v, output int act_c);
    req_write = v[25]; req_bank = v[24:23]; req_row = v[22:10]; req_col = v[9:0];
    req_valid = 1;
    while (!req_ready) step();
    step();
    req_valid = 0;
    act_c = cyc;
    chk("R8 ready low after accept", 32'(req_ready), 0);
    repeat (T_RCD) step();
    chk("R3 ACTIVE code (R9)", 32'(lg_cmd[n_log-2]), 32'(C_ACT));
    chk("R3 ACTIVE cycle", 32'(lg_cyc[n_log-2]), 32'(act_c));
    chk("R3 ACTIVE bank", 32'(lg_ba[n_log-2]), 32'(v[24:23]));
    chk("R3 ACTIVE row", 32'(lg_addr[n_log-2]), 32'(v[22:10]));
    chk("R4 READ/WRITE code (R9)", 32'(lg_cmd[n_log-1]), 32'(v[25] ? C_WR : C_RD));
    chk("R4 tRCD spacing", 32'(lg_cyc[n_log-1] - lg_cyc[n_log-2]), 32'(T_RCD));
    chk("R4 column bank", 32'(lg_ba[n_log-1]), 32'(v[24:23]));
    chk("R4 column addr with A10", 32'(lg_addr[n_log-1]), 32'({3'b001, v[9:0]}));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog R1 actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c_rel, act_c, s, e, bad, nref, last_ref, prev_ref, other;
    repeat (3) step();
    chk("R1 reset NOP (R9)", 32'({cs_n, ras_n, cas_n, we_n}), 32'(C_NOP));
    chk("R1 ready low in reset", 32'(req_ready), 0);
    rst_n = 1;
    c_rel = cyc;
    repeat (INIT_WAIT - 2) step();
    chk("R1 ready low during init", 32'(req_ready), 0);

    // first vector waits while init completes
    send(VECS[0], act_c);
    chk("R2 PRECHARGE ALL code", 32'(lg_cmd[0]), 32'(C_PRE));
    chk("R2 PRECHARGE ALL A10", 32'(lg_addr[0][10]), 1);
    chk("R2 PRECHARGE ALL cycle", 32'(lg_cyc[0] - c_rel), 32'(INIT_WAIT));
    chk("R2 first refresh", 32'(lg_cmd[1]), 32'(C_REF));
    chk("R2 tRP spacing", 32'(lg_cyc[1] - lg_cyc[0]), 32'(T_RP));
    chk("R2 second refresh", 32'(lg_cmd[2]), 32'(C_REF));
    chk("R2 tRFC spacing", 32'(lg_cyc[2] - lg_cyc[1]), 32'(T_RFC));
    chk("R2 load mode code", 32'(lg_cmd[3]), 32'(C_LMR));
    chk("R2 load mode spacing", 32'(lg_cyc[3] - lg_cyc[2]), 32'(T_RFC));
    chk("R2 mode word", 32'(lg_addr[3]), 32'(CAS_LAT * 16));
    chk("R2 first ACTIVE after mode", 32'(act_c - lg_cyc[3]), 32'(T_MRD));

    for (int i = 1; i < 6; i++) begin
      repeat (i) step();
      send(VECS[i], act_c);
    end

    // continuous stream: exact spacing and refresh priority
    req_write = 1; req_bank = 2'd2; req_row = 13'h0777; req_col = 10'h0F0;
    s = n_log;
    req_valid = 1;
    repeat (500) step();
    req_valid = 0;
    e = n_log;
    bad = 0; nref = 0; other = 0;
    for (int k = s + 1; k < e; k++) begin
      if (lg_cmd[k] == C_REF) nref++;
      if ((lg_cmd[k-1] == C_WR) && (lg_cyc[k] - lg_cyc[k-1] != AP_GAP)) bad++;
      if ((lg_cmd[k-1] == C_REF) && (lg_cyc[k] - lg_cyc[k-1] != T_RFC)) other++;
      if ((lg_cmd[k-1] == C_ACT) && (lg_cmd[k] != C_WR)) nref = -1000;
    end
    chk("R5 stream gap after access", 32'(bad), 0);
    chk("R7 stream gap after refresh", 32'(other), 0);
    chk("R6 refreshes served in stream", 32'(nref >= 2), 1);

    // idle: fields toggle, valid low
    repeat (20) step();
    s = n_log;
    for (int k = 0; k < 3 * REF_INTERVAL + 20; k++) begin
      req_bank = 2'(k); req_row = 13'(k * 37); req_col = 10'(k * 5); req_write = k[0];
      step();
    end
    other = 0; nref = 0; last_ref = 0; prev_ref = 0;
    for (int k = s; k < n_log; k++) begin
      if (lg_cmd[k] != C_REF) other++;
      else begin nref++; prev_ref = last_ref; last_ref = lg_cyc[k]; end
    end
    chk("R8 no command from idle fields", 32'(other), 0);
    chk("R6 idle refresh count", 32'(nref >= 2), 1);
    chk("R6 idle refresh spacing", 32'(last_ref - prev_ref), 32'(REF_INTERVAL));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule